// File: doc/BRIEF.md
# Multichannel Bit-Transposing Sample Packer

This block watches up to sixteen digital input lines and, on each pulse of a sample strobe, records one level per line. After sixteen strobes it holds a 16-bit history for every line. It then hands those histories out as a byte stream: one word per enabled line, lines in rising index order, each word split into two bytes. The stream is line-major, so every word is the time history of a single line rather than a snapshot of all lines at one instant.

Collection and output overlap. While one group of words drains through a byte-wide valid/ready port toward a USB FIFO, the next sixteen samples gather in a separate shift bank. The finished group moves into the output bank only once the previous group has fully left. A group that finishes while bytes are still pending is discarded and a sticky overflow flag is raised. Line selection comes from an enable mask: bit c enables line c. The intended masks are 0x0007, 0x003F, 0x01FF and 0xFFFF. The strobe rate has to be chosen so that the byte rate stays within what the sink accepts. At full output speed, the tightest case is sixteen lines with one strobe every second clock.

Top module: `bitplane_packer`

## Requirements
- R1: After reset, out_valid is 0 and overflow is 0.
- R2: In each word, bit k holds the level of that line at the k-th strobe of the group (bit 0 is the oldest sample, 1 means high).
- R3: Each word leaves as two consecutive bytes: bits 7..0 first, then bits 15..8.
- R4: Within a group, words leave in ascending line index, starting at the lowest enabled line. Lines whose mask bit is 0 produce no bytes.
- R5: After the last enabled line of a group, the next group starts again at the lowest enabled line.
- R6: The masks 0x0007, 0x003F, 0x01FF and 0xFFFF each yield 3, 6, 9 and 16 words per group respectively. Any other mask works the same way.
- R7: The enable mask is captured at the first strobe of a group and nowhere else, so changing chan_en during a group has no effect on that group.
- R8: A completed group takes over the output bank when no bytes are pending, or in the same cycle as the final byte of the previous group is accepted. In that case there is no overflow and no idle cycle.
- R9: If a group completes while bytes of the previous group are still pending (other than the last one being accepted), that group is dropped and overflow goes to 1. Overflow stays 1 until reset, and later groups are still packed.
- R10: A group captured with mask 0 produces no output: out_valid stays 0.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Line enable mask, bit c enables line c |
| chan_in | input | NCH | Raw line levels |
| smp_stb | input | 1 | Sample strobe, one sample per high cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Sink accepts the byte this cycle |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
Two events can fall in the same clock cycle: a group completing collection, and the final byte of the previous group being accepted. The bench provokes this with all sixteen lines enabled, one strobe every second clock, and out_ready held high. In that setting the drain of one group ends exactly on the cycle the next group completes. The result is judged by two checks: overflow must stay 0, and the received byte stream must match the computed histories of every group without loss.

// File: rtl/bitplane_pkg.sv
package bitplane_pkg;

  localparam int WORD_BITS = 16;
  localparam int BYTE_BITS = 8;
  localparam int CNT_BITS  = $clog2(WORD_BITS);

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // Newest sample enters at the top, so bit 0 ends up oldest.
  function automatic logic [WORD_BITS-1:0] shift_in(input logic [WORD_BITS-1:0] w,
                                                    input logic b);
    return {b, w[WORD_BITS-1:1]};
  endfunction

  function automatic logic [BYTE_BITS-1:0] pick_half(input logic [WORD_BITS-1:0] w,
                                                     input half_e h);
    return (h == HALF_HI) ? w[WORD_BITS-1 -: BYTE_BITS] : w[BYTE_BITS-1:0];
  endfunction

endpackage

// File: rtl/bitplane_collect.sv
module bitplane_collect
  import bitplane_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           chan_en,
  input  logic [NCH-1:0]           chan_in,
  input  logic                     smp_stb,
  output logic [NCH*WORD_BITS-1:0] words,
  output logic [NCH-1:0]           grp_mask,
  output logic                     grp_done
);

  localparam logic [CNT_BITS-1:0] LAST_IDX = CNT_BITS'(WORD_BITS - 1);

  logic [CNT_BITS-1:0] cnt;
  logic                at_first;
  logic                at_last;

  assign at_first = (cnt == '0);
  assign at_last  = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      grp_mask <= '0;
      grp_done <= 1'b0;
    end else begin
      grp_done <= 1'b0;
      if (smp_stb) begin
        if (at_first) grp_mask <= chan_en;
        cnt <= at_last ? '0 : cnt + 1'b1;
        if (at_last) grp_done <= 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_line
    logic [WORD_BITS-1:0] hist;
    always_ff @(posedge clk) begin
      if (!rst_n)       hist <= '0;
      else if (smp_stb) hist <= shift_in(hist, chan_in[c]);
    end
    assign words[c*WORD_BITS +: WORD_BITS] = hist;
  end

endmodule

// File: rtl/bitplane_bank.sv
module bitplane_bank
  import bitplane_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NCH*WORD_BITS-1:0] words_in,
  input  logic [CW-1:0]            sel,
  input  half_e                    half,
  output logic [BYTE_BITS-1:0]     byte_out
);

  logic [WORD_BITS-1:0] hold [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)    hold[c] <= '0;
      else if (load) hold[c] <= words_in[c*WORD_BITS +: WORD_BITS];
    end
  end

  assign byte_out = pick_half(hold[sel], half);

endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
  import bitplane_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_done,
  input  logic [NCH-1:0] grp_mask,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [CW-1:0]  cur,
  output half_e          half,
  output logic           swap,
  output logic           drop,
  output logic           last_fire,
  output logic           overflow
);

  function automatic logic [CW-1:0] first_set(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) if (m[i]) r = CW'(i);
    return r;
  endfunction

  function automatic logic [NCH-1:0] one_bit(input logic [CW-1:0] i);
    return {{(NCH-1){1'b0}}, 1'b1} << i;
  endfunction

  logic [NCH-1:0] pend;
  logic           busy;
  logic           fire;
  logic           free;
  logic           real_grp;

  assign busy      = |pend;
  assign cur       = first_set(pend);
  assign fire      = busy && out_ready;
  assign last_fire = fire && (half == HALF_HI) && ((pend & ~one_bit(cur)) == '0);
  assign free      = !busy || last_fire;
  assign real_grp  = grp_done && (|grp_mask);
  assign swap      = real_grp && free;
  assign drop      = real_grp && !free;
  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      half     <= HALF_LO;
      overflow <= 1'b0;
    end else begin
      if (drop) overflow <= 1'b1;
      if (swap) begin
        pend <= grp_mask;
        half <= HALF_LO;
      end else if (fire) begin
        if (half == HALF_HI) begin
          pend <= pend & ~one_bit(cur);
          half <= HALF_LO;
        end else begin
          half <= HALF_HI;
        end
      end
    end
  end

endmodule

// File: rtl/bitplane_packer.sv
module bitplane_packer
  import bitplane_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH-1:0]       chan_in,
  input  logic                 smp_stb,
  output logic [BYTE_BITS-1:0] out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 overflow
);

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH*WORD_BITS-1:0] words;
  logic [NCH-1:0]           grp_mask;
  logic                     grp_done;
  logic [CW-1:0]            cur;
  half_e                    half;
  logic                     swap_ev;
  logic                     drop_ev;
  logic                     last_fire;

  bitplane_collect #(.NCH(NCH)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .chan_in  (chan_in),
    .smp_stb  (smp_stb),
    .words    (words),
    .grp_mask (grp_mask),
    .grp_done (grp_done)
  );

  bitplane_seq #(.NCH(NCH), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_done  (grp_done),
    .grp_mask  (grp_mask),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .cur       (cur),
    .half      (half),
    .swap      (swap_ev),
    .drop      (drop_ev),
    .last_fire (last_fire),
    .overflow  (overflow)
  );

  bitplane_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (swap_ev),
    .words_in (words),
    .sel      (cur),
    .half     (half),
    .byte_out (out_data)
  );

endmodule

// File: rtl/bitplane_packer_chk.sv
module bitplane_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       overflow,
  input logic       grp_done,
  input logic       swap_ev,
  input logic       drop_ev,
  input logic       last_fire
);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  drop_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> overflow);

  // R9
  drop_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> (out_valid && grp_done));

  // R8
  swap_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev |=> out_valid);

  // R8
  last_fire_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |-> (out_valid && out_ready));

endmodule

bind bitplane_packer bitplane_packer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .overflow  (overflow),
  .grp_done  (grp_done),
  .swap_ev   (swap_ev),
  .drop_ev   (drop_ev),
  .last_fire (last_fire)
);

// File: tb/bitplane_packer_test.sv
module bitplane_packer_test;

  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH-1:0] chan_in = '0;
  logic           smp_stb = 1'b0;
  logic [7:0]     out_data;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic           overflow;

  int checks = 0;
  int errors = 0;

  logic [7:0] expq[$];
  logic [7:0] gotq[$];
  logic       watch_idle = 1'b0;
  logic       toggle_rdy = 1'b0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #10 clk = ~clk;

  bitplane_packer #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_in(chan_in),
    .smp_stb(smp_stb), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .overflow(overflow)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int g, input int s);
    int t;
    t = g * 40503 + s * 9973 + (g ^ s) * 257 + 17;
    return t[15:0] ^ {t[7:0], t[15:8]};
  endfunction

  // Monitor: bytes, stall hold (R11), idle watch (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && (out_data == prev_data), "R11 stall hold", int'(out_data), int'(prev_data));
      if (watch_idle) check(!out_valid, "R10 zero mask idle", int'(out_valid), 0);
      if (out_valid && out_ready) gotq.push_back(out_data);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else prev_stall = 1'b0;
  end

  // Ready toggler
  int rcnt = 0;
  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    if (toggle_rdy) out_ready <= #1 ((rcnt % 3) != 0);
  end

  function automatic void push_expected(input int g, input logic [15:0] m);
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        logic [15:0] w;
        for (int s = 0; s < 16; s++) w[s] = pat(g, s)[c];
        expq.push_back(w[7:0]);
        expq.push_back(w[15:8]);
      end
    end
  endfunction

  // Called at posedge+1; returns at posedge+1
  task automatic do_group(input int g, input logic [15:0] m, input int gap, input logic keep);
    for (int s = 0; s < 16; s++) begin
      chan_en = (s == 0) ? m : (~m ^ 16'(s));
      chan_in = pat(g, s);
      smp_stb = 1'b1;
      @(posedge clk); #1;
      smp_stb = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
    chan_en = ~m;
    if (keep) push_expected(g, m);
  endtask

  task automatic drain_compare(input string tag);
    repeat (4) begin @(posedge clk); #1; end
    while (out_valid) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    check(gotq.size() == expq.size(), {tag, " byte count"}, gotq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < gotq.size(); i++)
      check(gotq[i] == expq[i], tag, int'(gotq[i]), int'(expq[i]));
    expq.delete();
    gotq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] masks [4];
    int g;
    masks[0] = 16'h0007; masks[1] = 16'h003F; masks[2] = 16'h01FF; masks[3] = 16'hFFFF;
    g = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
    check(!overflow, "R1 reset overflow", int'(overflow), 0);
    @(posedge clk); #1;

    // Supported masks, two groups each, mask noise mid-group
    for (int k = 0; k < 4; k++) begin
      do_group(g, masks[k], 3, 1'b1); g++;
      do_group(g, masks[k], 3, 1'b1); g++;
      drain_compare("R2 R3 R4 R5 R6 R7 mask sweep");
    end

    // Sparse mask with a stalling sink
    toggle_rdy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      do_group(g, 16'hA5C1, 5, 1'b1); g++;
    end
    drain_compare("R4 R11 sparse stalled");
    toggle_rdy = 1'b0;
    @(posedge clk); #1; out_ready = 1'b1;
    @(posedge clk); #1;

    // Group completion on the cycle the last byte leaves
    for (int k = 0; k < 4; k++) begin
      do_group(g, 16'hFFFF, 1, 1'b1); g++;
    end
    drain_compare("R8 back-to-back swap");
    check(!overflow, "R8 no overflow on coincident swap", int'(overflow), 0);

    // Zero mask
    watch_idle = 1'b1;
    do_group(g, 16'h0000, 1, 1'b0); g++;
    repeat (6) begin @(posedge clk); #1; end
    watch_idle = 1'b0;
    drain_compare("R10 zero mask bytes");

    // Overflow: sink blocked
    out_ready = 1'b0;
    do_group(g, 16'h0007, 1, 1'b1); g++;
    do_group(g, 16'h0007, 1, 1'b0); g++;
    repeat (3) begin @(posedge clk); #1; end
    check(overflow, "R9 overflow set", int'(overflow), 1);
    out_ready = 1'b1;
    drain_compare("R9 dropped group absent");
    do_group(g, 16'h0038, 2, 1'b1); g++;
    drain_compare("R9 later group packed");
    check(overflow, "R9 overflow sticky", int'(overflow), 1);
    rst_n = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    rst_n = 1'b1;
    @(negedge clk);
    check(!overflow, "R9 overflow cleared by reset", int'(overflow), 0);
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule